// File: doc/BRIEF.md
# Low-Power Mode and Pin-State Controller

This block sits beside an 8-bit microcontroller core and handles its two sleep states. Software requests a light sleep (idle) or a deep sleep (power-down) with a one-cycle request strobe. In idle the block stops the CPU clock and leaves the peripheral clocks running. In power-down it also turns off the oscillator enable. While either state lasts, the block holds the address-latch and program-store strobes at fixed levels and tells each of the four ports how to drive its pins.

Idle ends on any enabled interrupt. Power-down ends only when one of the two external interrupt lines is asserted. After such a wake the oscillator comes up first, and the clocks are released only after a stabilisation count that software can set. A hardware reset ends either state at once. The reset reinitialises the control state but touches nothing that holds memory contents, so RAM is preserved. The port drive modes depend on the sleep state and on whether program memory is internal or external.

Top module: `lpm_ctrl`

## Requirements
- R1: While `rst` is high and afterwards until a request, the block is running: `cpu_clk_en`, `per_clk_en`, `osc_en`, `ale_lvl` and `psen_lvl` are 1 and `port_mode` is all zero (code 00 = core in control, for every port).
- R2: A `req_idle` strobe seen at a clock edge while running makes `cpu_clk_en` 0 from that edge, while `per_clk_en` and `osc_en` stay 1.
- R3: In idle, any bit of `irq_pend` or of `ext_irq` seen at an edge returns the block to running, with `cpu_clk_en` at 1 from that edge.
- R4: A `req_pd` strobe seen at an edge while running makes `osc_en`, `cpu_clk_en` and `per_clk_en` all 0 from that edge.
- R5: In power-down, `irq_pend` has no effect. Only a 1 on `ext_irq[0]` or `ext_irq[1]` starts a wake.
- R6: On an external-interrupt wake from power-down, `osc_en` goes to 1 at the waking edge. `cpu_clk_en` and `per_clk_en` go to 1 exactly `stab_count`+1 clock cycles later.
- R7: If `req_idle` and `req_pd` are both high at the same edge, power-down is entered.
- R8: `ale_lvl` and `psen_lvl` are 1 in idle. They are 0 in power-down and during the stabilisation wait.
- R9: Port n uses `port_mode[2n+1:2n]`, with codes 01 = drive latched data, 10 = drive address, 11 = float. With `ext_mem`=1, port 0 is 11 in both sleep states. Port 2 is 10 in idle and 01 in power-down. Ports 1 and 3 are 01.
- R10: With `ext_mem`=0, all four ports are 01 in both sleep states.
- R11: Raising `rst` during idle or power-down returns all outputs to their R1 values without waiting for a clock edge.
- R12: Request strobes are ignored while not running: `req_pd` in idle leaves `per_clk_en` at 1, and `req_idle` in power-down leaves `osc_en` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running controller clock |
| rst | input | 1 | Hardware reset, active high, asynchronous |
| req_idle | input | 1 | One-cycle strobe requesting idle |
| req_pd | input | 1 | One-cycle strobe requesting power-down |
| irq_pend | input | NIRQ | Enabled, pending on-chip interrupts |
| ext_irq | input | 2 | Enabled, asserted external interrupt lines |
| ext_mem | input | 1 | 1 when program memory is external |
| stab_count | input | STAB_W | Oscillator stabilisation wait, in cycles minus one |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| osc_en | output | 1 | Oscillator enable |
| ale_lvl | output | 1 | Forced address-latch strobe level |
| psen_lvl | output | 1 | Forced program-store strobe level |
| port_mode | output | 8 | Drive mode per port, two bits each |

## Verification
On every cycle the assertions check several properties. In power-down without an external interrupt the oscillator stays off. Idle without a wake source keeps the CPU clock stopped and the peripheral clock running. A power-down request while running always turns the oscillator off. The oscillator rises before the CPU clock does. The sweeps are needed for the rest: the exact length of the stabilisation wait for each count, the port mode table for each memory setting, and the asynchronous effect of reset. They also show that ignored requests and interrupts leave the outputs unchanged.

// File: rtl/lpm_ctrl.sv
module lpm_ctrl #(
  parameter int NIRQ   = 5,
  parameter int STAB_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_idle,
  input  logic              req_pd,
  input  logic [NIRQ-1:0]   irq_pend,
  input  logic [1:0]        ext_irq,
  input  logic              ext_mem,
  input  logic [STAB_W-1:0] stab_count,
  output logic              cpu_clk_en,
  output logic              per_clk_en,
  output logic              osc_en,
  output logic              ale_lvl,
  output logic              psen_lvl,
  output logic [7:0]        port_mode
);

  localparam logic [1:0] MD_CORE  = 2'b00;
  localparam logic [1:0] MD_DATA  = 2'b01;
  localparam logic [1:0] MD_ADDR  = 2'b10;
  localparam logic [1:0] MD_FLOAT = 2'b11;

  typedef enum logic [1:0] {S_RUN, S_IDLE, S_PD, S_WARM} st_t;

  st_t              st;
  logic [STAB_W-1:0] cnt;

  wire wake_light = (|irq_pend) | (|ext_irq);
  wire wake_deep  = |ext_irq;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      st  <= S_RUN;
      cnt <= '0;
    end else begin
      case (st)
        S_RUN: begin
          if (req_pd)        st <= S_PD;
          else if (req_idle) st <= S_IDLE;
        end
        S_IDLE: if (wake_light) st <= S_RUN;
        S_PD: begin
          if (wake_deep) begin
            st  <= S_WARM;
            cnt <= stab_count;
          end
        end
        default: begin
          if (cnt == '0) st <= S_RUN;
          else           cnt <= cnt - 1'b1;
        end
      endcase
    end
  end

  wire asleep = (st != S_RUN);
  wire deep   = (st == S_PD) || (st == S_WARM);

  assign cpu_clk_en = (st == S_RUN);
  assign per_clk_en = (st == S_RUN) || (st == S_IDLE);
  assign osc_en     = (st != S_PD);
  assign ale_lvl    = !deep;
  assign psen_lvl   = !deep;

  wire [1:0] p0 = !asleep ? MD_CORE : (ext_mem ? MD_FLOAT : MD_DATA);
  wire [1:0] p1 = !asleep ? MD_CORE : MD_DATA;
  wire [1:0] p2 = !asleep ? MD_CORE : ((ext_mem && !deep) ? MD_ADDR : MD_DATA);
  wire [1:0] p3 = !asleep ? MD_CORE : MD_DATA;

  assign port_mode = {p3, p2, p1, p0};

  assert_pd_no_stray_wake_R5: assert property (@(posedge clk) disable iff (rst)
    (st == S_PD && ext_irq == 2'b00) |=> !osc_en);

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (st == S_IDLE && !wake_light) |=> (!cpu_clk_en && per_clk_en));

  assert_pd_priority_R7: assert property (@(posedge clk) disable iff (rst)
    (st == S_RUN && req_pd) |=> (!osc_en && !per_clk_en));

  assert_osc_first_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(osc_en) |-> !cpu_clk_en);

  assert_ignore_req_R12: assert property (@(posedge clk) disable iff (rst)
    (st == S_IDLE && req_pd && !wake_light) |=> per_clk_en);

endmodule

// File: tb/tb_lpm_ctrl.sv
module tb_lpm_ctrl;
  localparam int NIRQ = 5;
  localparam int SW   = 8;

  logic clk = 0, rst = 1, req_idle = 0, req_pd = 0, ext_mem = 0;
  logic [NIRQ-1:0] irq_pend = '0;
  logic [1:0] ext_irq = '0;
  logic [SW-1:0] stab_count = '0;
  logic cpu_clk_en, per_clk_en, osc_en, ale_lvl, psen_lvl;
  logic [7:0] port_mode;

  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  lpm_ctrl #(.NIRQ(NIRQ), .STAB_W(SW)) dut (
    .clk(clk), .rst(rst), .req_idle(req_idle), .req_pd(req_pd),
    .irq_pend(irq_pend), .ext_irq(ext_irq), .ext_mem(ext_mem),
    .stab_count(stab_count), .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en),
    .osc_en(osc_en), .ale_lvl(ale_lvl), .psen_lvl(psen_lvl), .port_mode(port_mode));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_ports(bit deep, bit ext);
    logic [1:0] p0, p2;
    p0 = ext ? 2'b11 : 2'b01;
    p2 = (ext && !deep) ? 2'b10 : 2'b01;
    return {2'b01, p2, 2'b01, p0};
  endfunction

  task automatic do_reset();
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    @(negedge clk);
  endtask

  task automatic pulse_req(bit i, bit p);
    req_idle = i; req_pd = p;
    @(negedge clk);
    req_idle = 0; req_pd = 0;
  endtask

  task automatic chk_run(string tag);
    chk({tag, " clocks"}, {cpu_clk_en, per_clk_en, osc_en, ale_lvl, psen_lvl}, 5'b11111);
    chk({tag, " ports"}, port_mode, 8'h00);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    chk_run("R1 during reset");
    do_reset();
    chk_run("R1 after reset");

    for (int ext = 0; ext < 2; ext++) begin
      ext_mem = ext[0];
      for (int src = 0; src < NIRQ + 2; src++) begin
        do_reset();
        pulse_req(1, 0);
        chk("R2 idle clocks", {cpu_clk_en, per_clk_en, osc_en}, 3'b011);
        chk("R8 idle strobes", {ale_lvl, psen_lvl}, 2'b11);
        chk(ext ? "R9 idle ports" : "R10 idle ports", port_mode, exp_ports(0, ext[0]));
        pulse_req(0, 1);
        chk("R12 pd req in idle", {cpu_clk_en, per_clk_en}, 2'b01);
        if (src < NIRQ) irq_pend = NIRQ'(1) << src;
        else            ext_irq = 2'(1) << (src - NIRQ);
        @(negedge clk);
        irq_pend = '0; ext_irq = '0;
        chk_run("R3 idle wake");
      end

      for (int s = 0; s < 6; s++) begin
        for (int e = 0; e < 2; e++) begin
          int n;
          do_reset();
          stab_count = SW'(s);
          pulse_req(0, 1);
          chk("R4 pd clocks", {cpu_clk_en, per_clk_en, osc_en}, 3'b000);
          chk("R8 pd strobes", {ale_lvl, psen_lvl}, 2'b00);
          chk(ext ? "R9 pd ports" : "R10 pd ports", port_mode, exp_ports(1, ext[0]));
          irq_pend = '1;
          @(negedge clk);
          @(negedge clk);
          irq_pend = '0;
          chk("R5 pd ignores irq", {cpu_clk_en, osc_en}, 2'b00);
          pulse_req(1, 0);
          chk("R12 idle req in pd", {per_clk_en, osc_en}, 2'b00);
          ext_irq = 2'(1) << e;
          @(negedge clk);
          ext_irq = '0;
          chk("R6 osc first", {osc_en, cpu_clk_en, per_clk_en}, 3'b100);
          chk("R8 warm strobes", {ale_lvl, psen_lvl}, 2'b00);
          n = 0;
          while (!cpu_clk_en && n < 300) begin
            @(negedge clk);
            n++;
          end
          chk("R6 stabilisation length", n, s + 1);
          chk_run("R6 after wake");
        end
      end
    end

    do_reset();
    pulse_req(1, 1);
    chk("R7 both requests", {osc_en, per_clk_en}, 2'b00);

    do_reset();
    pulse_req(0, 1);
    #3 rst = 1; #1;
    chk_run("R11 reset ends pd");
    @(negedge clk); rst = 0;
    @(negedge clk);
    pulse_req(1, 0);
    #3 rst = 1; #1;
    chk_run("R11 reset ends idle");
    @(negedge clk); rst = 0;

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule